// File: doc/BRIEF.md
# Serial-bus command slave for a four-channel setting controller

This block is the two-wire serial front end of a four-channel, 64-step setting controller. It samples the bus clock and data lines on a fast system clock, finds START and STOP conditions, and checks an 8-bit device address. The address has the fixed pattern 0101 in its upper nibble and four strap inputs in its lower nibble. After the address comes an instruction byte. That byte selects an operation, one of four stored registers and one of four channels. The block then takes one data byte in, returns one data byte, or carries out a copy between a channel's live setting and one of its stored registers. The only output onto the bus is an open-drain pull-down enable for the data line.

Each channel has a live 6-bit setting and a bank of four 6-bit stored registers. The stored registers stand in for non-volatile storage. A write to a stored register commits only at the closing STOP. That STOP also starts a programming timer. While the timer runs, the block refuses every address byte. A host can therefore poll by sending START plus the address until it gets an acknowledge.

Top module: `wiper_bus_slave`

## Requirements
- R1: A falling data line while the clock is high is a START. It restarts address reception from the first bit in any state, including the middle of a byte. A rising data line while the clock is high is a STOP and returns the block to idle. Before the first START the block ignores the bus.
- R2: An address byte is acknowledged only when bits 7..4 are 0101 and bits 3..0 equal the strap inputs. The acknowledge is a pull-down during the ninth clock. On a mismatch the block does not acknowledge that byte or any later byte before the next START.
- R3: Instruction byte fields are: bits 7..4 opcode, bits 3..2 stored-register select, bits 1..0 channel select. The valid opcodes are 1001 read setting, 1010 write setting, 1011 read stored register, 1100 write stored register, 1101 load setting from stored register, and 1110 save setting into stored register. Any other opcode is not acknowledged, and later bytes are ignored until the next START.
- R4: Opcode 1010 writes bits 5..0 of the acknowledged data byte into the selected channel's setting and ignores bits 7..6. Other channels keep their values. Any byte after that data byte is not acknowledged.
- R5: A read returns {2'b00, value} MSB first, one bit per clock, and releases the line in the ninth clock. If the host acknowledges, the same byte is sent again. If it does not, the block releases the line until the next START.
- R6: Opcode 1100 stores bits 5..0 of its data byte into the selected stored register. The store and the busy flag begin at the closing STOP, never before it. A repeated START before that STOP cancels the store.
- R7: Opcode 1101 copies the selected stored register into the selected channel's setting as soon as the instruction byte is acknowledged, without waiting for a STOP.
- R8: Opcode 1110 copies the selected channel's setting into the selected stored register at the closing STOP and starts the busy flag.
- R9: The busy output stays high for exactly WRITE_CYCLES system clocks after a commit. While it is high, no address byte is acknowledged. After it falls, a matching address is acknowledged again.
- R10: The pull-down output changes only while the synchronized bus clock is low.
- R11: After reset the pull-down and busy outputs are low, and every setting and stored register is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 8x the bus clock rate |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_in | input | 1 | Bus clock line, asynchronous |
| sda_in | input | 1 | Bus data line as seen on the wire, asynchronous |
| dev_strap | input | 4 | Device address straps, compared against address bits 3..0 |
| sda_pull_low | output | 1 | High to pull the data line low (open-drain enable) |
| prog_busy | output | 1 | Programming timer running |
| wiper_levels | output | 24 | Channel settings, channel k at bits 6k+5..6k |

## Verification
Every bus event is seen two synchronizer stages plus one edge-detect register after it happens on the pins. An acknowledge or a read bit therefore shows up about three system clocks after the bus clock falls. The bench drives data three clocks after each clock fall and samples the line five clocks into the high phase, so those delays settle well before any sample. A setting written by a data byte or loaded by opcode 1101 is in place a few clocks after the eighth rising edge, and the checks read it only after the ninth clock has finished. The busy flag rises about three clocks after the STOP on the pins. Its length is measured edge to edge against WRITE_CYCLES, and polls are placed right after the STOP and again after the fall.

// File: rtl/wbs_pkg.sv
// Shared encodings for the serial command slave: engine states, byte roles,
// device identifier and the opcode set. Assumes 8-bit bus bytes.
package wbs_pkg;

    localparam int          NUM_CH  = 4;
    localparam int          NUM_REG = 4;
    localparam logic [3:0]  DEV_ID  = 4'b0101;

    localparam logic [3:0] OP_RD_SET  = 4'b1001;
    localparam logic [3:0] OP_WR_SET  = 4'b1010;
    localparam logic [3:0] OP_RD_REG  = 4'b1011;
    localparam logic [3:0] OP_WR_REG  = 4'b1100;
    localparam logic [3:0] OP_LOAD    = 4'b1101;
    localparam logic [3:0] OP_SAVE    = 4'b1110;

    typedef enum logic [2:0] {
        ST_IDLE, ST_RECV, ST_DECIDE, ST_HOLD, ST_ACK, ST_SEND, ST_MACK, ST_RELOAD
    } eng_state_t;

    typedef enum logic [1:0] {
        BK_ADDR, BK_INSTR, BK_DATA
    } byte_kind_t;

    typedef enum logic [1:0] {
        NX_IDLE, NX_RECV, NX_SEND
    } next_t;

endpackage

// File: rtl/wbs_bus_sync.sv
// Bus line conditioner: brings the asynchronous clock and data lines into the
// system clock domain and flags clock edges, START and STOP. Assumes the
// system clock runs at least 8x the bus clock. Idle bus level is high.
module wbs_bus_sync #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_raw,
    input  logic sda_raw,
    output logic scl_lvl,
    output logic sda_lvl,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    logic [SYNC_STAGES-1:0] scl_pipe;
    logic [SYNC_STAGES-1:0] sda_pipe;
    logic                   scl_prev;
    logic                   sda_prev;

    // Shift the raw lines through the synchronizer chain and keep one delayed copy.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_pipe <= '1;
            sda_pipe <= '1;
            scl_prev <= 1'b1;
            sda_prev <= 1'b1;
        end else begin
            scl_pipe <= {scl_pipe[SYNC_STAGES-2:0], scl_raw};
            sda_pipe <= {sda_pipe[SYNC_STAGES-2:0], sda_raw};
            scl_prev <= scl_pipe[SYNC_STAGES-1];
            sda_prev <= sda_pipe[SYNC_STAGES-1];
        end
    end

    assign scl_lvl = scl_pipe[SYNC_STAGES-1];
    assign sda_lvl = sda_pipe[SYNC_STAGES-1];

    // Edge and bus-condition flags, one cycle wide.
    always_comb begin
        scl_rise  = scl_lvl & ~scl_prev;
        scl_fall  = ~scl_lvl & scl_prev;
        start_det = scl_lvl & scl_prev & sda_prev & ~sda_lvl;
        stop_det  = scl_lvl & scl_prev & ~sda_prev & sda_lvl;
    end

endmodule

// File: rtl/wbs_cmd_engine.sv
// Byte-level protocol engine: receives the address, instruction and data
// bytes, decides acknowledges, shifts read bytes out and issues register
// operations. Assumes conditioned inputs from wbs_bus_sync and VAL_W <= 8.
module wbs_cmd_engine
    import wbs_pkg::*;
#(
    parameter int VAL_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             scl_lvl,
    input  logic             sda_lvl,
    input  logic             scl_rise,
    input  logic             scl_fall,
    input  logic             start_det,
    input  logic             stop_det,
    input  logic [3:0]       strap,
    input  logic             busy,
    input  logic [VAL_W-1:0] rd_set_val,
    input  logic [VAL_W-1:0] rd_reg_val,
    output logic             sda_low,
    output logic [1:0]       sel_chan,
    output logic [1:0]       sel_reg,
    output logic [VAL_W-1:0] wr_val,
    output logic             wr_set_en,
    output logic             load_set_en,
    output logic             commit_en,
    output logic             commit_from_set
);
    eng_state_t  state;
    byte_kind_t  kind;
    next_t       nxt;
    logic [7:0]  shreg;
    logic [7:0]  txreg;
    logic [2:0]  bitcnt;
    logic [3:0]  cmd_op;
    logic        ack_addr;
    logic        pend_commit;
    logic [7:0]  rd_byte;
    logic        op_known;

    // Byte presented by a read: value right-aligned, upper bits zero.
    always_comb begin
        rd_byte = '0;
        rd_byte[VAL_W-1:0] = (cmd_op == OP_RD_SET) ? rd_set_val : rd_reg_val;
    end

    // Opcode of the received byte is one of the six supported operations.
    always_comb begin
        op_known = (shreg[7:4] == OP_RD_SET) || (shreg[7:4] == OP_WR_SET) ||
                   (shreg[7:4] == OP_RD_REG) || (shreg[7:4] == OP_WR_REG) ||
                   (shreg[7:4] == OP_LOAD)   || (shreg[7:4] == OP_SAVE);
    end

    // Main protocol sequencer: bus conditions first, then the per-state bit work.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state           <= ST_IDLE;
            kind            <= BK_ADDR;
            nxt             <= NX_IDLE;
            shreg           <= '0;
            txreg           <= '0;
            bitcnt          <= '0;
            cmd_op          <= '0;
            sel_chan        <= '0;
            sel_reg         <= '0;
            wr_val          <= '0;
            ack_addr        <= 1'b0;
            pend_commit     <= 1'b0;
            commit_from_set <= 1'b0;
            wr_set_en       <= 1'b0;
            load_set_en     <= 1'b0;
        end else begin
            wr_set_en   <= 1'b0;
            load_set_en <= 1'b0;
            if (start_det) begin
                state       <= ST_RECV;
                kind        <= BK_ADDR;
                bitcnt      <= '0;
                ack_addr    <= 1'b0;
                pend_commit <= 1'b0;
            end else if (stop_det) begin
                state       <= ST_IDLE;
                pend_commit <= 1'b0;
            end else begin
                case (state)
                    ST_RECV: begin
                        if (scl_rise) begin
                            shreg <= {shreg[6:0], sda_lvl};
                            if (bitcnt == 3'd7) state <= ST_DECIDE;
                            else                bitcnt <= bitcnt + 3'd1;
                        end
                    end
                    ST_DECIDE: begin
                        state <= ST_IDLE;
                        case (kind)
                            BK_ADDR: begin
                                if (shreg[7:4] == DEV_ID && shreg[3:0] == strap && !busy) begin
                                    state    <= ST_HOLD;
                                    kind     <= BK_INSTR;
                                    nxt      <= NX_RECV;
                                    ack_addr <= 1'b1;
                                end
                            end
                            BK_INSTR: begin
                                ack_addr <= 1'b0;
                                cmd_op   <= shreg[7:4];
                                sel_reg  <= shreg[3:2];
                                sel_chan <= shreg[1:0];
                                if (op_known) state <= ST_HOLD;
                                case (shreg[7:4])
                                    OP_RD_SET, OP_RD_REG: nxt <= NX_SEND;
                                    OP_WR_SET, OP_WR_REG: begin
                                        nxt  <= NX_RECV;
                                        kind <= BK_DATA;
                                    end
                                    OP_LOAD: begin
                                        nxt         <= NX_IDLE;
                                        load_set_en <= 1'b1;
                                    end
                                    OP_SAVE: begin
                                        nxt             <= NX_IDLE;
                                        pend_commit     <= 1'b1;
                                        commit_from_set <= 1'b1;
                                    end
                                    default: nxt <= NX_IDLE;
                                endcase
                            end
                            BK_DATA: begin
                                state  <= ST_HOLD;
                                nxt    <= NX_IDLE;
                                wr_val <= shreg[VAL_W-1:0];
                                if (cmd_op == OP_WR_SET) wr_set_en <= 1'b1;
                                else begin
                                    pend_commit     <= 1'b1;
                                    commit_from_set <= 1'b0;
                                end
                            end
                            default: state <= ST_IDLE;
                        endcase
                    end
                    ST_HOLD: begin
                        if (scl_fall) state <= ST_ACK;
                    end
                    ST_ACK: begin
                        if (scl_fall) begin
                            bitcnt <= '0;
                            case (nxt)
                                NX_RECV: state <= ST_RECV;
                                NX_SEND: begin
                                    txreg <= rd_byte;
                                    state <= ST_SEND;
                                end
                                default: state <= ST_IDLE;
                            endcase
                        end
                    end
                    ST_SEND: begin
                        if (scl_fall) begin
                            if (bitcnt == 3'd7) state <= ST_MACK;
                            else begin
                                txreg  <= {txreg[6:0], 1'b0};
                                bitcnt <= bitcnt + 3'd1;
                            end
                        end
                    end
                    ST_MACK: begin
                        if (scl_rise) state <= sda_lvl ? ST_IDLE : ST_RELOAD;
                    end
                    ST_RELOAD: begin
                        if (scl_fall) begin
                            txreg  <= rd_byte;
                            bitcnt <= '0;
                            state  <= ST_SEND;
                        end
                    end
                    default: state <= ST_IDLE;
                endcase
            end
        end
    end

    // Open-drain drive: acknowledge slot, or a zero bit of a read byte.
    assign sda_low   = (state == ST_ACK) || (state == ST_SEND && !txreg[7]);
    // A pending stored-register write fires on the closing STOP.
    assign commit_en = stop_det && pend_commit;

    // R1
    start_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start_det |=> (state == ST_RECV && kind == BK_ADDR && bitcnt == 3'd0));

    // R10
    sda_quiet_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sda_low != $past(sda_low)) |-> !scl_lvl);

    // R9
    no_ack_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_ACK && ack_addr) |-> !busy);

    // R3
    bad_op_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_DECIDE && kind == BK_INSTR && !op_known && !start_det && !stop_det)
        |=> state == ST_IDLE);

endmodule

// File: rtl/wbs_setting_bank.sv
// Storage for the live channel settings and the stored-register banks, plus
// the programming timer that models a non-volatile write. Assumes at most one
// operation strobe per cycle from wbs_cmd_engine.
module wbs_setting_bank
    import wbs_pkg::*;
#(
    parameter int VAL_W        = 6,
    parameter int WRITE_CYCLES = 5000
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [1:0]              sel_chan,
    input  logic [1:0]              sel_reg,
    input  logic [VAL_W-1:0]        wr_val,
    input  logic                    wr_set_en,
    input  logic                    load_set_en,
    input  logic                    commit_en,
    input  logic                    commit_from_set,
    output logic [VAL_W-1:0]        rd_set_val,
    output logic [VAL_W-1:0]        rd_reg_val,
    output logic                    busy,
    output logic [NUM_CH*VAL_W-1:0] set_flat
);
    localparam int CNT_W = $clog2(WRITE_CYCLES + 1);

    logic [VAL_W-1:0] setting [NUM_CH];
    logic [VAL_W-1:0] stored  [NUM_CH][NUM_REG];
    logic [CNT_W-1:0] prog_cnt;

    // Live settings: direct write or load from the selected stored register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int c = 0; c < NUM_CH; c++) setting[c] <= '0;
        end else if (wr_set_en) begin
            setting[sel_chan] <= wr_val;
        end else if (load_set_en) begin
            setting[sel_chan] <= stored[sel_chan][sel_reg];
        end
    end

    // Stored registers: commit from the data byte or from the live setting.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int c = 0; c < NUM_CH; c++)
                for (int r = 0; r < NUM_REG; r++) stored[c][r] <= '0;
        end else if (commit_en) begin
            stored[sel_chan][sel_reg] <= commit_from_set ? setting[sel_chan] : wr_val;
        end
    end

    // Programming timer: loaded at each commit, counts down to idle.
    always_ff @(posedge clk) begin
        if (!rst_n)              prog_cnt <= '0;
        else if (commit_en)      prog_cnt <= CNT_W'(WRITE_CYCLES);
        else if (prog_cnt != '0) prog_cnt <= prog_cnt - 1'b1;
    end

    assign busy       = (prog_cnt != '0);
    assign rd_set_val = setting[sel_chan];
    assign rd_reg_val = stored[sel_chan][sel_reg];

    for (genvar g = 0; g < NUM_CH; g++) begin : g_flat
        assign set_flat[g*VAL_W +: VAL_W] = setting[g];
    end

    // R6
    commit_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        commit_en |=> busy);

    // R9
    busy_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !(commit_en || wr_set_en || load_set_en));

    // R4
    setting_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_set_en || load_set_en) |=> set_flat == $past(set_flat));

endmodule

// File: rtl/wiper_bus_slave.sv
// Top level of the serial command slave: line conditioner, protocol engine
// and setting storage. Assumes clk is at least 8x the bus clock rate and that
// the bus is not stretched or shared by several masters.
module wiper_bus_slave #(
    parameter int VAL_W        = 6,
    parameter int WRITE_CYCLES = 5000,
    parameter int SYNC_STAGES  = 2
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            scl_in,
    input  logic                            sda_in,
    input  logic [3:0]                      dev_strap,
    output logic                            sda_pull_low,
    output logic                            prog_busy,
    output logic [wbs_pkg::NUM_CH*VAL_W-1:0] wiper_levels
);
    logic             scl_lvl, sda_lvl, scl_rise, scl_fall, start_det, stop_det;
    logic [1:0]       sel_chan, sel_reg;
    logic [VAL_W-1:0] wr_val, rd_set_val, rd_reg_val;
    logic             wr_set_en, load_set_en, commit_en, commit_from_set;

    wbs_bus_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_raw   (scl_in),
        .sda_raw   (sda_in),
        .scl_lvl   (scl_lvl),
        .sda_lvl   (sda_lvl),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det)
    );

    wbs_cmd_engine #(.VAL_W(VAL_W)) u_engine (
        .clk             (clk),
        .rst_n           (rst_n),
        .scl_lvl         (scl_lvl),
        .sda_lvl         (sda_lvl),
        .scl_rise        (scl_rise),
        .scl_fall        (scl_fall),
        .start_det       (start_det),
        .stop_det        (stop_det),
        .strap           (dev_strap),
        .busy            (prog_busy),
        .rd_set_val      (rd_set_val),
        .rd_reg_val      (rd_reg_val),
        .sda_low         (sda_pull_low),
        .sel_chan        (sel_chan),
        .sel_reg         (sel_reg),
        .wr_val          (wr_val),
        .wr_set_en       (wr_set_en),
        .load_set_en     (load_set_en),
        .commit_en       (commit_en),
        .commit_from_set (commit_from_set)
    );

    wbs_setting_bank #(.VAL_W(VAL_W), .WRITE_CYCLES(WRITE_CYCLES)) u_bank (
        .clk             (clk),
        .rst_n           (rst_n),
        .sel_chan        (sel_chan),
        .sel_reg         (sel_reg),
        .wr_val          (wr_val),
        .wr_set_en       (wr_set_en),
        .load_set_en     (load_set_en),
        .commit_en       (commit_en),
        .commit_from_set (commit_from_set),
        .rd_set_val      (rd_set_val),
        .rd_reg_val      (rd_reg_val),
        .busy            (prog_busy),
        .set_flat        (wiper_levels)
    );

endmodule

// File: tb/wiper_bus_slave_test.sv
// Directed bench: a bit-level bus master model, one task per scenario.
module wiper_bus_slave_test;
    localparam int WC = 5000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        scl_m = 1'b1;
    logic        sda_m = 1'b1;
    logic [3:0]  strap = 4'hA;
    logic        drv, busy;
    logic [23:0] levels;
    logic        sda_line;
    int          total = 0, bad = 0, cyc = 0;
    int          rise_t = 0, fall_t = 0, r10_viol = 0;
    logic        prev_busy = 1'b0, prev_drv = 1'b0;
    bit          done = 1'b0;

    assign sda_line = sda_m & ~drv;

    always #10 clk = ~clk;

    wiper_bus_slave #(.WRITE_CYCLES(WC)) uut (
        .clk          (clk),
        .rst_n        (rst_n),
        .scl_in       (scl_m),
        .sda_in       (sda_line),
        .dev_strap    (strap),
        .sda_pull_low (drv),
        .prog_busy    (busy),
        .wiper_levels (levels)
    );

    // Cycle count, busy edge times and pull-down changes while the clock line is high.
    always @(negedge clk) begin
        cyc++;
        if (busy && !prev_busy) rise_t = cyc;
        if (!busy && prev_busy) fall_t = cyc;
        if (rst_n && (drv != prev_drv) && scl_m) r10_viol++;
        prev_busy = busy;
        prev_drv  = drv;
    end

    task automatic check(string tag, int act, int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wt(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_start();
        if (!scl_m) begin
            wt(3); sda_m = 1'b1; wt(7); scl_m = 1'b1; wt(5);
        end else wt(5);
        sda_m = 1'b0; wt(5); scl_m = 1'b0;
    endtask

    task automatic bus_stop();
        wt(3); sda_m = 1'b0; wt(7); scl_m = 1'b1; wt(5); sda_m = 1'b1; wt(10);
    endtask

    task automatic put_bit(logic b);
        wt(3); sda_m = b; wt(7); scl_m = 1'b1; wt(10); scl_m = 1'b0;
    endtask

    task automatic get_bit(output logic b);
        wt(3); sda_m = 1'b1; wt(7); scl_m = 1'b1; wt(5); b = sda_line; wt(5); scl_m = 1'b0;
    endtask

    task automatic send_byte(logic [7:0] d, output logic ack);
        logic b;
        for (int i = 7; i >= 0; i--) put_bit(d[i]);
        get_bit(b);
        ack = !b;
    endtask

    task automatic recv_byte(output logic [7:0] d, input logic host_ack);
        for (int i = 7; i >= 0; i--) get_bit(d[i]);
        put_bit(!host_ack);
    endtask

    // Full read of setting (op 1001) or stored register (op 1011), single byte.
    task automatic read_one(logic [7:0] instr, string tag, int exp);
        logic a; logic [7:0] d;
        bus_start();
        send_byte(8'h5A, a);
        send_byte(instr, a);
        check({tag, " instr ack"}, a, 1);
        recv_byte(d, 1'b0);
        check({tag, " read data"}, d, exp);
        bus_stop();
    endtask

    task automatic wait_idle();
        while (busy) wt(1);
        wt(5);
    endtask

    task automatic t_reset();
        check("R11 pull-down", drv, 0);
        check("R11 busy", busy, 0);
        check("R11 settings", levels, 0);
        read_one(8'hBF, "R11 stored ch3 reg3", 8'h00);
    endtask

    task automatic t_address();
        logic a;
        bus_start(); send_byte(8'h6A, a); check("R2 wrong id nack", a, 0);
        send_byte(8'hA2, a); check("R2 ignored after mismatch", a, 0); bus_stop();
        bus_start(); send_byte(8'h5B, a); check("R2 wrong strap nack", a, 0); bus_stop();
        bus_start(); send_byte(8'h5A, a); check("R2 match ack", a, 1); bus_stop();
    endtask

    task automatic t_write_setting();
        logic a;
        bus_start();
        send_byte(8'h5A, a);
        send_byte(8'hA2, a); check("R4 instr ack", a, 1);
        send_byte(8'hFF, a); check("R4 data ack", a, 1);
        check("R4 ch2 top bits dropped", levels[17:12], 6'h3F);
        check("R4 other channels", {levels[23:18], levels[11:0]}, 0);
        send_byte(8'h11, a); check("R4 extra byte nack", a, 0);
        bus_stop();
        check("R4 no commit", busy, 0);
    endtask

    task automatic t_read_repeat();
        logic a; logic [7:0] d;
        bus_start();
        send_byte(8'h5A, a);
        send_byte(8'h92, a); check("R5 instr ack", a, 1);
        recv_byte(d, 1'b1); check("R5 first byte", d, 8'h3F);
        recv_byte(d, 1'b0); check("R5 repeated byte", d, 8'h3F);
        recv_byte(d, 1'b0); check("R5 released after nack", d, 8'hFF);
        bus_stop();
    endtask

    task automatic t_write_stored();
        logic a;
        bus_start();
        send_byte(8'h5A, a);
        send_byte(8'hCD, a); check("R6 instr ack", a, 1);
        send_byte(8'h55, a); check("R6 data ack", a, 1);
        wt(30); check("R6 not busy before STOP", busy, 0);
        bus_stop();
        check("R6 busy after STOP", busy, 1);
        bus_start(); send_byte(8'h5A, a); bus_stop();
        check("R9 poll nack while busy", a, 0);
        wait_idle();
        check("R9 busy length", fall_t - rise_t, WC);
        bus_start(); send_byte(8'h5A, a); bus_stop();
        check("R9 poll ack after busy", a, 1);
        read_one(8'hBD, "R6 stored ch1 reg3", 8'h15);
    endtask

    task automatic t_bad_opcode();
        logic a;
        bus_start();
        send_byte(8'h5A, a);
        send_byte(8'h02, a); check("R3 bad opcode nack", a, 0);
        send_byte(8'hA0, a); check("R3 idle after bad opcode", a, 0);
        bus_stop();
        check("R3 settings unchanged", levels, 24'h03F000);
    endtask

    task automatic t_load();
        logic a;
        bus_start();
        send_byte(8'h5A, a);
        send_byte(8'hDD, a); check("R7 instr ack", a, 1);
        wt(5);
        check("R7 ch1 loaded before STOP", levels[11:6], 6'h15);
        bus_stop();
        check("R7 no busy", busy, 0);
    endtask

    task automatic t_save();
        logic a;
        bus_start();
        send_byte(8'h5A, a);
        send_byte(8'hE2, a); check("R8 instr ack", a, 1);
        wt(30); check("R8 not busy before STOP", busy, 0);
        bus_stop();
        check("R8 busy after STOP", busy, 1);
        wait_idle();
        read_one(8'hB2, "R8 stored ch2 reg0", 8'h3F);
    endtask

    task automatic t_cancel();
        logic a;
        bus_start();
        send_byte(8'h5A, a);
        send_byte(8'hC4, a);
        send_byte(8'h2A, a); check("R6 cancel data ack", a, 1);
        bus_start();
        bus_stop();
        wt(20);
        check("R6 repeated START cancels busy", busy, 0);
        read_one(8'hB4, "R6 cancelled store", 8'h00);
    endtask

    task automatic t_mid_start();
        logic a; logic [7:0] d;
        bus_start();
        put_bit(1'b0); put_bit(1'b1); put_bit(1'b1); put_bit(1'b0);
        bus_start();
        send_byte(8'h5A, a); check("R1 restart address ack", a, 1);
        send_byte(8'h91, a);
        recv_byte(d, 1'b0); check("R1 read after restart", d, 8'h15);
        bus_stop();
        check("R1 idle after STOP", drv, 0);
    endtask

    initial begin
        wt(5);
        rst_n = 1'b1;
        wt(5);
        t_reset();
        t_address();
        t_write_setting();
        t_read_repeat();
        t_write_stored();
        t_bad_opcode();
        t_load();
        t_save();
        t_cancel();
        t_mid_start();
        check("R10 drive changes while clock high", r10_viol, 0);
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule